// File: doc/BRIEF.md
# Auto-refresh request scheduler with postponement credit

This block decides when a four-bank DDR memory is owed an AUTO REFRESH. It counts clock cycles against a programmable interval (the 7.8 us average spacing, divided by the clock period, for example 1040 cycles at 133 MHz). Each time the interval elapses, one refresh is added to an owed count. The count holds at most eight refreshes. Because of this credit, a command arbiter can postpone refreshes during heavy traffic and later issue them back to back. The block raises a request only while every bank is precharged. After each granted refresh it holds the request off for the refresh row-cycle time.

The same block runs self-refresh. An entry request is taken only when the banks are idle and no refresh row cycle is in progress. Entry clears the owed count and freezes the interval counter. An exit request starts a wake-up timer. This timer first allows non-read commands and, later, read commands. Normal refresh requests resume once reads are allowed.

Top module: `aref_sched`

## Requirements
- R1: After reset the owed count is 0, `ref_req`, `ref_urgent` and `sr_active` are low, and `nonread_ok` and `read_ok` are high.
- R2: The interval counter advances only in cycles with `tick_en` high outside self-refresh. After every `interval_cyc` such cycles the owed count rises by one (`interval_cyc` must be at least 1).
- R3: `ref_req` is high exactly when the owed count is nonzero, `banks_idle` is high, no refresh row cycle is in progress and the block is in normal operation.
- R4: A `ref_grant` sampled while `ref_req` is high lowers the owed count by one. A `ref_grant` sampled while `ref_req` is low has no effect.
- R5: When an interval tick and an accepted grant fall in the same cycle, the owed count is unchanged.
- R6: The owed count saturates at MAX_OWED (8). `ref_urgent` is high exactly while the count equals MAX_OWED.
- R7: After an accepted grant, `ref_req` stays low for TRFC cycles (10 by default).
- R8: An `sr_enter` accepted in normal operation with `banks_idle` high and no refresh row cycle in progress has these effects. It clears the owed count and raises `sr_active`. While `sr_active` is high the owed count stays 0, the interval counter is frozen and `ref_req` is low.
- R9: If `sr_leave` is sampled while `sr_active` is high, `sr_active` falls. `nonread_ok` then rises XSNR cycles later (10 by default) and `read_ok` rises XSRD cycles later (200 by default). `ref_req` stays low until `read_ok` is high.
- R10: An `sr_enter` is ignored when `banks_idle` is low, during a refresh row cycle, or outside normal operation. If a grant and an accepted entry coincide, the entry wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick_en | input | 1 | Lets the interval counter advance this cycle |
| interval_cyc | input | IW | Refresh interval in clock cycles |
| ref_grant | input | 1 | Arbiter issued the requested refresh |
| banks_idle | input | 1 | All four banks are precharged |
| sr_enter | input | 1 | Request to enter self-refresh |
| sr_leave | input | 1 | Request to leave self-refresh |
| ref_req | output | 1 | Refresh request toward the arbiter |
| ref_urgent | output | 1 | Owed count is at its limit |
| owed_cnt | output | CW | Number of refreshes owed |
| sr_active | output | 1 | Memory is in self-refresh |
| nonread_ok | output | 1 | Non-read commands allowed |
| read_ok | output | 1 | Read commands allowed |

## Verification
The owed count is first driven to its ceiling with the banks busy. This separates saturation and the urgent flag from request gating. It also shows that grants made without a request are ignored. A drain with `ref_grant` held high measures the row-cycle hold gap between accepted grants. A phase with a short interval and a continuous grant makes ticks and grants coincide, so the net-zero case can be told apart from a lost or doubled update. The self-refresh sequence tries entry while busy and during a row cycle. It then checks that no refresh accrues while asleep, that the counter is frozen across the sleep, and that the two wake-up gaps are counted separately.

// File: rtl/aref_pkg.sv
package aref_pkg;

  typedef enum logic [1:0] {
    SR_RUN  = 2'd0,
    SR_HOLD = 2'd1,
    SR_WAKE = 2'd2
  } sr_state_t;

  // Interval elapsed when the count reaches the programmed length minus one.
  function automatic logic interval_hit(input logic [31:0] cnt, input logic [31:0] intv);
    return (cnt + 32'd1) >= intv;
  endfunction

  // Saturating credit update: one up, one down, both cancel.
  function automatic logic [31:0] credit_next(input logic [31:0] owed,
                                              input logic        inc,
                                              input logic        dec,
                                              input logic [31:0] cap);
    logic [31:0] v;
    v = owed;
    if (inc && !dec)      v = (owed >= cap) ? cap : owed + 32'd1;
    else if (dec && !inc) v = (owed == 32'd0) ? 32'd0 : owed - 32'd1;
    return v;
  endfunction

endpackage

// File: rtl/aref_interval_timer.sv
module aref_interval_timer
  import aref_pkg::*;
#(
  parameter int IW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          run,
  input  logic [IW-1:0] interval,
  output logic          tick
);

  logic [IW-1:0] cnt_q;

  assign tick = run && interval_hit(32'(cnt_q), 32'(interval));

  always_ff @(posedge clk) begin
    if (!rst_n)   cnt_q <= '0;
    else if (run) cnt_q <= tick ? '0 : cnt_q + 1'b1;
  end

endmodule

// File: rtl/aref_credit_ctr.sv
module aref_credit_ctr
  import aref_pkg::*;
#(
  parameter  int MAX_OWED = 8,
  parameter  int TRFC     = 10,
  localparam int CW       = $clog2(MAX_OWED + 1),
  localparam int RW       = $clog2(TRFC + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tick,
  input  logic          take,
  input  logic          clear,
  output logic [CW-1:0] owed,
  output logic          full,
  output logic          hold
);

  logic [CW-1:0] owed_q;
  logic [RW-1:0] rfc_q;

  assign owed = owed_q;
  assign full = (owed_q == CW'(MAX_OWED));
  assign hold = (rfc_q != '0);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      owed_q <= '0;
      rfc_q  <= '0;
    end else begin
      owed_q <= clear ? '0
                      : CW'(credit_next(32'(owed_q), tick, take, 32'(MAX_OWED)));
      if (take)      rfc_q <= RW'(TRFC);
      else if (hold) rfc_q <= rfc_q - 1'b1;
    end
  end

endmodule

// File: rtl/aref_sr_ctrl.sv
module aref_sr_ctrl
  import aref_pkg::*;
#(
  parameter  int XSNR = 10,
  parameter  int XSRD = 200,
  localparam int XW   = $clog2(XSRD + 1)
) (
  input  logic clk,
  input  logic rst_n,
  input  logic enter,
  input  logic leave,
  input  logic can_enter,
  output logic go,
  output logic frozen,
  output logic in_run,
  output logic nonread_ok
);

  sr_state_t     state_q;
  logic [XW-1:0] tmr_q;

  assign in_run     = (state_q == SR_RUN);
  assign frozen     = (state_q == SR_HOLD);
  assign go         = in_run && enter && can_enter;
  assign nonread_ok = in_run || ((state_q == SR_WAKE) && (tmr_q >= XW'(XSNR)));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q <= SR_RUN;
      tmr_q   <= '0;
    end else begin
      case (state_q)
        SR_RUN:  if (go) state_q <= SR_HOLD;
        SR_HOLD: if (leave) begin
                   state_q <= SR_WAKE;
                   tmr_q   <= '0;
                 end
        SR_WAKE: begin
                   tmr_q <= tmr_q + 1'b1;
                   if (tmr_q == XW'(XSRD - 1)) state_q <= SR_RUN;
                 end
        default: state_q <= SR_RUN;
      endcase
    end
  end

endmodule

// File: rtl/aref_sched.sv
module aref_sched
  import aref_pkg::*;
#(
  parameter  int IW       = 16,
  parameter  int MAX_OWED = 8,
  parameter  int TRFC     = 10,
  parameter  int XSNR     = 10,
  parameter  int XSRD     = 200,
  localparam int CW       = $clog2(MAX_OWED + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tick_en,
  input  logic [IW-1:0] interval_cyc,
  input  logic          ref_grant,
  input  logic          banks_idle,
  input  logic          sr_enter,
  input  logic          sr_leave,
  output logic          ref_req,
  output logic          ref_urgent,
  output logic [CW-1:0] owed_cnt,
  output logic          sr_active,
  output logic          nonread_ok,
  output logic          read_ok
);

  // Named internal events, also observed by the bound checker.
  logic tick;
  logic sr_go;
  logic grant_take;
  logic rfc_hold;
  logic sr_frozen;
  logic in_run;

  aref_interval_timer #(.IW(IW)) u_timer (
    .clk      (clk),
    .rst_n    (rst_n),
    .run      (tick_en && !sr_frozen),
    .interval (interval_cyc),
    .tick     (tick)
  );

  aref_credit_ctr #(.MAX_OWED(MAX_OWED), .TRFC(TRFC)) u_credit (
    .clk   (clk),
    .rst_n (rst_n),
    .tick  (tick),
    .take  (grant_take),
    .clear (sr_go),
    .owed  (owed_cnt),
    .full  (ref_urgent),
    .hold  (rfc_hold)
  );

  aref_sr_ctrl #(.XSNR(XSNR), .XSRD(XSRD)) u_sr (
    .clk        (clk),
    .rst_n      (rst_n),
    .enter      (sr_enter),
    .leave      (sr_leave),
    .can_enter  (banks_idle && !rfc_hold),
    .go         (sr_go),
    .frozen     (sr_frozen),
    .in_run     (in_run),
    .nonread_ok (nonread_ok)
  );

  assign ref_req    = (owed_cnt != '0) && banks_idle && !rfc_hold && in_run;
  assign grant_take = ref_grant && ref_req && !sr_go;
  assign sr_active  = sr_frozen;
  assign read_ok    = in_run;

endmodule

// File: rtl/aref_sched_chk.sv
module aref_sched_chk #(
  parameter  int MAX_OWED = 8,
  localparam int CW       = $clog2(MAX_OWED + 1)
) (
  input logic          clk,
  input logic          rst_n,
  input logic          ref_req,
  input logic          ref_grant,
  input logic          banks_idle,
  input logic [CW-1:0] owed_cnt,
  input logic          ref_urgent,
  input logic          sr_active,
  input logic          nonread_ok,
  input logic          read_ok,
  input logic          tick,
  input logic          sr_go
);

  AST_TICK_ADDS: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && !(ref_grant && ref_req) && !sr_go && owed_cnt < CW'(MAX_OWED))
      |=> owed_cnt == $past(owed_cnt) + 1'b1); // R2

  AST_REQ_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    ref_req |-> banks_idle); // R3

  AST_GRANT_TAKES: assert property (@(posedge clk) disable iff (!rst_n)
    (ref_grant && ref_req && !tick && !sr_go)
      |=> owed_cnt == $past(owed_cnt) - 1'b1); // R4

  AST_COINCIDE_NET: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && ref_grant && ref_req && !sr_go) |=> $stable(owed_cnt)); // R5

  AST_OWED_CAP: assert property (@(posedge clk) disable iff (!rst_n)
    owed_cnt <= CW'(MAX_OWED)); // R6

  AST_URGENT_RISE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ref_urgent) |-> $past(owed_cnt) == CW'(MAX_OWED - 1)); // R6

  AST_RFC_GAP: assert property (@(posedge clk) disable iff (!rst_n)
    (ref_grant && ref_req && !sr_go) |=> !ref_req); // R7

  AST_SR_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    sr_go |=> (owed_cnt == '0) && sr_active); // R8

  AST_SR_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    sr_active |-> !ref_req && owed_cnt == '0); // R8

  AST_READ_ORDER: assert property (@(posedge clk) disable iff (!rst_n)
    read_ok |-> nonread_ok); // R9

endmodule

bind aref_sched aref_sched_chk #(.MAX_OWED(MAX_OWED)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .ref_req    (ref_req),
  .ref_grant  (ref_grant),
  .banks_idle (banks_idle),
  .owed_cnt   (owed_cnt),
  .ref_urgent (ref_urgent),
  .sr_active  (sr_active),
  .nonread_ok (nonread_ok),
  .read_ok    (read_ok),
  .tick       (tick),
  .sr_go      (sr_go)
);

// File: tb/sim_aref_sched.sv
module sim_aref_sched;

  localparam int IW = 16, MAXO = 8, TRFC = 10, XSNR = 10, XSRD = 200;

  logic clk = 1'b0, rst_n = 1'b0;
  logic tick_en = 1'b0, ref_grant = 1'b0, banks_idle = 1'b0;
  logic sr_enter = 1'b0, sr_leave = 1'b0;
  logic [IW-1:0] interval_cyc = 16'd5;
  logic ref_req, ref_urgent, sr_active, nonread_ok, read_ok;
  logic [3:0] owed_cnt;

  int total = 0, bad = 0;
  bit finished = 0;

  always #10 clk = ~clk;

  aref_sched u0 (
    .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .interval_cyc(interval_cyc),
    .ref_grant(ref_grant), .banks_idle(banks_idle), .sr_enter(sr_enter),
    .sr_leave(sr_leave), .ref_req(ref_req), .ref_urgent(ref_urgent),
    .owed_cnt(owed_cnt), .sr_active(sr_active), .nonread_ok(nonread_ok),
    .read_ok(read_ok)
  );

  task automatic chk(input string tag, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  // Behavioural reference: mode 0 normal, 1 asleep, 2 waking.
  int m_cnt = 0, m_owed = 0, m_rfc = 0, m_mode = 0, m_wake = 0, m_coinc = 0;

  function automatic bit m_req();
    return m_owed > 0 && banks_idle && m_rfc == 0 && m_mode == 0;
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      m_cnt = 0; m_owed = 0; m_rfc = 0; m_mode = 0; m_wake = 0;
    end else begin
      bit enter_ok, got, tk;
      int n_owed;
      enter_ok = (m_mode == 0) && sr_enter && banks_idle && (m_rfc == 0);
      got      = ref_grant && m_req() && !enter_ok;
      tk       = tick_en && (m_mode != 1) && (m_cnt + 1 >= int'(interval_cyc));
      if (tk && got) m_coinc++;
      if (tick_en && m_mode != 1) m_cnt = tk ? 0 : m_cnt + 1;
      n_owed = m_owed + (tk ? 1 : 0) - (got ? 1 : 0);
      if (n_owed > MAXO) n_owed = MAXO;
      m_owed = enter_ok ? 0 : n_owed;
      if (got) m_rfc = TRFC; else if (m_rfc > 0) m_rfc--;
      case (m_mode)
        0: if (enter_ok) m_mode = 1;
        1: if (sr_leave) begin m_mode = 2; m_wake = 0; end
        default: begin
          if (m_wake == XSRD - 1) m_mode = 0;
          m_wake++;
        end
      endcase
    end
    #5;
    if (rst_n && !finished) begin
      chk("R2/R4/R5 owed_cnt", int'(owed_cnt), m_owed);
      chk("R3 ref_req", int'(ref_req), int'(m_req()));
      chk("R6 ref_urgent", int'(ref_urgent), int'(m_owed == MAXO));
      chk("R8 sr_active", int'(sr_active), int'(m_mode == 1));
      chk("R9 nonread_ok", int'(nonread_ok),
          int'(m_mode == 0 || (m_mode == 2 && m_wake >= XSNR)));
      chk("R9 read_ok", int'(read_ok), int'(m_mode == 0));
    end
  end

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    #(20 * 150000);
    bad++; total++;
    $display("FAIL watchdog expired");
    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    int lo_nr, lo_rd, gap, saved;
    step(3);
    rst_n = 1'b1;
    step(1);
    chk("R1 owed", int'(owed_cnt), 0);
    chk("R1 req", int'(ref_req), 0);
    chk("R1 urgent", int'(ref_urgent), 0);
    chk("R1 sr_active", int'(sr_active), 0);
    chk("R1 ok flags", int'({nonread_ok, read_ok}), 3);

    // R6: banks busy, owed count climbs and saturates
    interval_cyc = 16'd5; tick_en = 1'b1;
    step(45);
    chk("R6 saturated", int'(owed_cnt), MAXO);
    chk("R6 urgent", int'(ref_urgent), 1);
    chk("R3 busy banks", int'(ref_req), 0);

    // R4: grant with no request is ignored
    ref_grant = 1'b1; step(1); ref_grant = 1'b0; step(1);
    chk("R4 grant ignored", int'(owed_cnt), MAXO);

    // R4 / R7: one accepted grant, then the row-cycle gap
    tick_en = 1'b0; banks_idle = 1'b1;
    step(1);
    chk("R3 request up", int'(ref_req), 1);
    ref_grant = 1'b1; step(1); ref_grant = 1'b0;
    chk("R4 owed down", int'(owed_cnt), MAXO - 1);
    chk("R6 urgent drop", int'(ref_urgent), 0);
    gap = 0;
    while (!ref_req && gap < 50) begin gap++; step(1); end
    chk("R7 hold cycles", gap, TRFC);

    // drain back to back
    ref_grant = 1'b1; step(120); ref_grant = 1'b0;
    chk("R4 drained", int'(owed_cnt), 0);

    // R2: gated counting, compared every cycle against the model
    banks_idle = 1'b0; interval_cyc = 16'd4;
    for (int i = 0; i < 40; i++) begin tick_en = i[0]; step(1); end

    // R5: ticks and grants coincide
    banks_idle = 1'b1; tick_en = 1'b1; interval_cyc = 16'd3; ref_grant = 1'b1;
    step(100);
    ref_grant = 1'b0;
    total++;
    if (m_coinc == 0) begin bad++; $display("FAIL R5 coincidence not reached actual=0 expected>0"); end

    // R10: entry refused while banks busy
    tick_en = 1'b0; banks_idle = 1'b0; step(12);
    saved = int'(owed_cnt);
    sr_enter = 1'b1; step(1); sr_enter = 1'b0;
    chk("R10 busy refuse", int'(sr_active), 0);
    chk("R10 owed kept", int'(owed_cnt), saved);

    // R10: entry refused during a row cycle
    banks_idle = 1'b1; step(1);
    chk("R3 req before sr", int'(ref_req), 1);
    ref_grant = 1'b1; step(1); ref_grant = 1'b0;
    sr_enter = 1'b1; step(1); sr_enter = 1'b0;
    chk("R10 hold refuse", int'(sr_active), 0);
    step(TRFC);

    // R8: accepted entry, then sleep with ticks enabled
    sr_enter = 1'b1; step(1); sr_enter = 1'b0;
    chk("R8 entered", int'(sr_active), 1);
    chk("R8 cleared", int'(owed_cnt), 0);
    chk("R8 no req", int'(ref_req), 0);
    tick_en = 1'b1; step(40);
    chk("R8 no accrual", int'(owed_cnt), 0);

    // R9: wake-up gaps
    sr_leave = 1'b1; step(1); sr_leave = 1'b0;
    chk("R9 left", int'(sr_active), 0);
    lo_nr = 0; lo_rd = 0;
    while (!read_ok && lo_rd < 400) begin
      if (!nonread_ok) lo_nr++;
      lo_rd++;
      step(1);
    end
    chk("R9 nonread gap", lo_nr, XSNR);
    chk("R9 read gap", lo_rd, XSRD);
    step(20);

    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule